// File: doc/BRIEF.md
# Serial Configuration Port

This block is a write-only, three-signal control port for a stereo audio converter. A host drives a serial clock, a data line and a latch strobe. While the latch is low, data bits are shifted in on serial clock rising edges, most significant bit first. A rising edge of the latch commits the last sixteen bits shifted. Two address bits in the committed word select one of four configuration registers. The register contents drive the converter's datapath: per-channel gain codes, mute, de-emphasis, forced bipolar zero, word length, channel routing, input format, word-clock polarity, shared gain control, sample-rate selection and zero-detect enable.

The three serial pins are asynchronous to the system clock. They are resynchronized and edge-detected in the system clock domain, so each high and low phase of the latch and the serial clock must last a few system clock periods. The gain registers hold a new code back from the active gain unless the word's load bit is set. Reset, from either power-on or the external pin, restores the defaults.

Top module: `serial_cfg_port`

## Requirements
- R1: After reset, the outputs take these values: att_l_o = att_r_o = 8'hFF, route_o = 4'b1001 (stereo), and every other output 0.
- R2: A word is shifted MSB first on synchronized serial clock rising edges while the latch is low. A latch rising edge commits the word, and word bits [10:9] pick the register: 0 left gain, 1 right gain, 2 mode, 3 format. A commit changes no field of any other register.
- R3: A latch arriving after fewer or more than 16 serial clocks commits the 16 most recently shifted bits. These can include bits left over from the previous word.
- R4: For a register 0 write, bit 8 is the load bit and bits [7:0] are the code. With load 1, the code becomes the active left gain. With load 0, the active left gain stays unchanged.
- R5: Register 1 behaves as R4 does, but for the right channel gain.
- R6: A register 2 write sets route_o from bits [8:5], wlen_o from [4:3], bpz_force_o from [2], deemph_o from [1] and mute_o from [0].
- R7: A register 3 write sets zd_en_o from bit [8], sr_sel_o from [7:6], dbl_sel_o from [5:4], att_common_o from [2], lr_pol_o from [1] and i2s_o from [0].
- R8: While att_common_o is 1, att_r_o shows the active left gain. While att_common_o is 0, att_r_o shows the active right gain.
- R9: Bits [15:11] of every word, and bit [3] of a register 3 word, have no effect on any output.
- R10: Serial clock edges that occur while the latch is high shift nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous) |
| ser_dat_i | input | 1 | Serial data (asynchronous) |
| ser_lat_i | input | 1 | Latch strobe; a rising edge commits the word |
| att_l_o | output | 8 | Active left gain code |
| att_r_o | output | 8 | Active right gain code, or the left code in shared mode |
| mute_o | output | 1 | Soft mute request |
| deemph_o | output | 1 | De-emphasis enable |
| bpz_force_o | output | 1 | Force output to bipolar zero |
| wlen_o | output | 2 | Input word length select |
| route_o | output | 4 | Output channel routing mode |
| i2s_o | output | 1 | I2S input format select |
| lr_pol_o | output | 1 | Word-clock polarity swap |
| att_common_o | output | 1 | Left gain applies to both channels |
| sr_sel_o | output | 2 | Sample-rate family select |
| dbl_sel_o | output | 2 | Double-rate select |
| zd_en_o | output | 1 | Zero-detect enable |

## Verification
The bench targets four cases. The first is a short latch and a long burst: a design that cleared its shift register or counted bits would write the wrong register or drop the new code. The second is serial clocks pulsed while the latch is high: a port that shifts on them commits a rotated word, which lands in register 0 and changes the left gain. The third is a gain write with its load bit clear: a design that ignores the load bit would move the active gain. The fourth is reserved bits set and the shared-gain switch toggled: a leaky decode corrupts fields, and a wrong output mux shows the stale right code.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned CODE_W   = 8;
  localparam int unsigned ADDR_LSB = 9;
  localparam int unsigned ADDR_W   = 2;
  localparam int unsigned LOAD_BIT = 8;
  localparam int unsigned N_CH     = 2;

  typedef enum logic [ADDR_W-1:0] {
    RA_GAIN_L = 2'd0,
    RA_GAIN_R = 2'd1,
    RA_MODE   = 2'd2,
    RA_FMT    = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [3:0] route;
    logic [1:0] wlen;
    logic       bpz;
    logic       deemph;
    logic       mute;
  } mode_reg_t;

  typedef struct packed {
    logic       zd_en;
    logic [1:0] sr_sel;
    logic [1:0] dbl_sel;
    logic       att_common;
    logic       lr_pol;
    logic       i2s;
  } fmt_reg_t;

  localparam mode_reg_t   MODE_RST = mode_reg_t'(9'h120);
  localparam fmt_reg_t    FMT_RST  = fmt_reg_t'(8'h00);
  localparam logic [CODE_W-1:0] GAIN_RST = '1;
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/scp_shift.sv
module scp_shift #(
  parameter int unsigned WORD_W = scp_pkg::WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdat_i,
  input  logic              slat_i,
  output logic              wr_stb_o,
  output logic [WORD_W-1:0] wr_word_o
);
  logic              sclk_q, slat_q;
  logic [WORD_W-1:0] sr_q;
  logic              sclk_rise, lat_rise;

  assign sclk_rise = sclk_i & ~sclk_q;
  assign lat_rise  = slat_i & ~slat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      slat_q <= 1'b0;
      sr_q   <= '0;
    end else begin
      sclk_q <= sclk_i;
      slat_q <= slat_i;
      // shift only while latch is low; no bit counter, history is kept
      if (sclk_rise && !slat_i) sr_q <= {sr_q[WORD_W-2:0], sdat_i};
    end
  end

  assign wr_stb_o  = lat_rise;
  assign wr_word_o = sr_q;
endmodule

// File: rtl/scp_regs.sv
module scp_regs
  import scp_pkg::*;
#(
  parameter int unsigned WORD_W = scp_pkg::WORD_W,
  parameter int unsigned CODE_W = scp_pkg::CODE_W,
  parameter int unsigned NCH    = scp_pkg::N_CH
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_stb_i,
  input  logic [WORD_W-1:0]          wr_word_i,
  output logic [NCH-1:0][CODE_W-1:0] gain_o,
  output mode_reg_t                  mode_o,
  output fmt_reg_t                   fmt_o
);
  localparam int unsigned MODE_W = $bits(mode_reg_t);

  reg_addr_e   addr;
  logic        load;
  logic [CODE_W-1:0] code;
  fmt_reg_t    fmt_d;
  logic        unused_bits;

  assign addr  = reg_addr_e'(wr_word_i[ADDR_LSB +: ADDR_W]);
  assign load  = wr_word_i[LOAD_BIT];
  assign code  = wr_word_i[CODE_W-1:0];
  assign fmt_d = fmt_reg_t'({wr_word_i[8:4], wr_word_i[2:0]});
  assign unused_bits = ^{wr_word_i[WORD_W-1:ADDR_LSB+ADDR_W], wr_word_i[3]};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [CODE_W-1:0] act_q;
    logic              hit;
    assign hit = wr_stb_i && (wr_word_i[ADDR_LSB +: ADDR_W] == ADDR_W'(ch)) && load;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  act_q <= GAIN_RST;
      else if (hit) act_q <= code;
    end
    assign gain_o[ch] = act_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= MODE_RST;
      fmt_o  <= FMT_RST;
    end else if (wr_stb_i) begin
      if (addr == RA_MODE) mode_o <= mode_reg_t'(wr_word_i[MODE_W-1:0]);
      if (addr == RA_FMT)  fmt_o  <= fmt_d;
    end
  end
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
  import scp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ser_clk_i,
  input  logic       ser_dat_i,
  input  logic       ser_lat_i,
  output logic [7:0] att_l_o,
  output logic [7:0] att_r_o,
  output logic       mute_o,
  output logic       deemph_o,
  output logic       bpz_force_o,
  output logic [1:0] wlen_o,
  output logic [3:0] route_o,
  output logic       i2s_o,
  output logic       lr_pol_o,
  output logic       att_common_o,
  output logic [1:0] sr_sel_o,
  output logic [1:0] dbl_sel_o,
  output logic       zd_en_o
);
  logic [2:0]                  pins_s;
  logic                        wr_stb;
  logic [WORD_W-1:0]           wr_word;
  logic [N_CH-1:0][CODE_W-1:0] gain;
  mode_reg_t                   mode;
  fmt_reg_t                    fmt;

  scp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ser_lat_i, ser_dat_i, ser_clk_i}),
    .q_o   (pins_s)
  );

  scp_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sclk_i   (pins_s[0]),
    .sdat_i   (pins_s[1]),
    .slat_i   (pins_s[2]),
    .wr_stb_o (wr_stb),
    .wr_word_o(wr_word)
  );

  scp_regs #(.WORD_W(WORD_W), .CODE_W(CODE_W), .NCH(N_CH)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_stb_i (wr_stb),
    .wr_word_i(wr_word),
    .gain_o   (gain),
    .mode_o   (mode),
    .fmt_o    (fmt)
  );

  assign att_l_o      = gain[0];
  assign att_r_o      = fmt.att_common ? gain[0] : gain[1];
  assign mute_o       = mode.mute;
  assign deemph_o     = mode.deemph;
  assign bpz_force_o  = mode.bpz;
  assign wlen_o       = mode.wlen;
  assign route_o      = mode.route;
  assign i2s_o        = fmt.i2s;
  assign lr_pol_o     = fmt.lr_pol;
  assign att_common_o = fmt.att_common;
  assign sr_sel_o     = fmt.sr_sel;
  assign dbl_sel_o    = fmt.dbl_sel;
  assign zd_en_o      = fmt.zd_en;
endmodule

// File: rtl/serial_cfg_port_chk.sv
module serial_cfg_port_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_stb,
  input logic [15:0] wr_word,
  input logic [7:0]  att_l_o,
  input logic [7:0]  att_r_o,
  input logic        att_common_o,
  input logic [1:0]  sr_sel_o,
  input logic [3:0]  route_o
);
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stb |=> ($stable(att_l_o) && $stable(att_r_o) && $stable(route_o) && $stable(sr_sel_o))); // R2

  AST_LEFT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb && wr_word[10:9] == 2'd0 && wr_word[8]) |=> att_l_o == $past(wr_word[7:0])); // R4

  AST_LEFT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb && wr_word[10:9] == 2'd0 && !wr_word[8]) |=> $stable(att_l_o)); // R4

  AST_RIGHT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb && wr_word[10:9] == 2'd1 && !wr_word[8]) |=> $stable(att_r_o)); // R5

  AST_FMT_RATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb && wr_word[10:9] == 2'd3) |=> sr_sel_o == $past(wr_word[7:6])); // R7

  AST_SHARED_GAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    att_common_o |-> att_r_o == att_l_o); // R8
endmodule

bind serial_cfg_port serial_cfg_port_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_stb      (wr_stb),
  .wr_word     (wr_word),
  .att_l_o     (att_l_o),
  .att_r_o     (att_r_o),
  .att_common_o(att_common_o),
  .sr_sel_o    (sr_sel_o),
  .route_o     (route_o)
);

// File: tb/serial_cfg_port_bench.sv
module serial_cfg_port_bench;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ser_clk_i = 1'b0, ser_dat_i = 1'b0, ser_lat_i = 1'b0;
  logic [7:0] att_l_o, att_r_o;
  logic mute_o, deemph_o, bpz_force_o, i2s_o, lr_pol_o, att_common_o, zd_en_o;
  logic [1:0] wlen_o, sr_sel_o, dbl_sel_o;
  logic [3:0] route_o;

  always #2 clk_i = ~clk_i;

  serial_cfg_port u_serial_cfg_port (.*);

  typedef struct {
    string       tag;
    logic [32:0] exp;
  } item_t;

  item_t q[$];
  event  ev_item;
  int    n_cmp = 0, n_bad = 0;
  bit    done = 0;

  logic [15:0] hist;
  logic [7:0]  m_gl, m_gr;
  logic [8:0]  m_mode;
  logic [7:0]  m_fmt;

  task automatic model_reset();
    hist = '0; m_gl = 8'hFF; m_gr = 8'hFF; m_mode = 9'h120; m_fmt = 8'h00;
  endtask

  task automatic model_apply(input logic [15:0] w);
    case (w[10:9])
      2'd0: if (w[8]) m_gl = w[7:0];
      2'd1: if (w[8]) m_gr = w[7:0];
      2'd2: m_mode = w[8:0];
      default: m_fmt = {w[8:4], w[2:0]};
    endcase
  endtask

  function automatic logic [32:0] model_vec();
    logic [7:0] r;
    r = m_fmt[2] ? m_gl : m_gr;
    return {m_gl, r, m_mode[0], m_mode[1], m_mode[2], m_mode[4:3], m_mode[8:5],
            m_fmt[0], m_fmt[1], m_fmt[2], m_fmt[6:5], m_fmt[4:3], m_fmt[7]};
  endfunction

  function automatic logic [32:0] dut_vec();
    return {att_l_o, att_r_o, mute_o, deemph_o, bpz_force_o, wlen_o, route_o,
            i2s_o, lr_pol_o, att_common_o, sr_sel_o, dbl_sel_o, zd_en_o};
  endfunction

  task automatic push(input string tag);
    item_t it;
    it.tag = tag;
    it.exp = model_vec();
    q.push_back(it);
    -> ev_item;
  endtask

  task automatic pulse_clk(input logic b, input bit track);
    @(negedge clk_i) ser_dat_i = b;
    repeat (3) @(negedge clk_i);
    ser_clk_i = 1'b1;
    if (track) hist = {hist[14:0], b};
    repeat (3) @(negedge clk_i);
    ser_clk_i = 1'b0;
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) pulse_clk(v[i], 1'b1);
  endtask

  task automatic commit(input string tag);
    @(negedge clk_i) ser_lat_i = 1'b1;
    model_apply(hist);
    repeat (8) @(negedge clk_i);
    push(tag);
    @(negedge clk_i) ser_lat_i = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic write_word(input logic [15:0] w, input string tag);
    send_bits({16'h0, w}, 16);
    commit(tag);
  endtask

  // monitor: pop and compare
  initial begin
    forever begin
      @(ev_item);
      #1;
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_cmp++;
        if (dut_vec() !== it.exp) begin
          n_bad++;
          $display("FAIL %s actual=%h expected=%h", it.tag, dut_vec(), it.exp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R2 watchdog actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    push("R1 reset defaults");

    write_word(16'h0040, "R2 R4 left code held, load bit 0");
    write_word(16'h0120, "R2 R4 left code loaded");
    write_word(16'h0211, "R5 right code held, load bit 0");
    write_word(16'h0333, "R5 right code loaded");
    write_word(16'h04D6, "R6 mode fields");
    write_word(16'h0757, "R7 R8 format fields, shared gain");
    write_word(16'hFE88, "R9 R8 reserved bits, separate gain");

    // long burst: 4 stale bits then a full word
    send_bits(32'hA, 4);
    send_bits({16'h0, 16'h017E}, 16);
    commit("R3 long burst keeps last 16");
    // short burst: only 4 new bits
    send_bits(32'h5, 4);
    commit("R3 short burst uses older bits");

    write_word(16'h0521, "R6 mode write before idle clocks");
    @(negedge clk_i) ser_lat_i = 1'b1;
    repeat (6) @(negedge clk_i);
    for (int k = 0; k < 3; k++) pulse_clk(1'b1, 1'b0);
    @(negedge clk_i) ser_lat_i = 1'b0;
    repeat (6) @(negedge clk_i);
    commit("R10 clocks during latch high");

    @(negedge clk_i) rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    model_reset();
    repeat (4) @(negedge clk_i);
    push("R1 external reset defaults");

    repeat (4) @(negedge clk_i);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule